// File: doc/BRIEF.md
# Analog Test Readout Column Selector

This block chooses which columns of a 960-column pixel matrix reach the 8 analog output pads during analog characterisation. In the stepping mode a window of 8 adjacent columns is held for a whole frame. At each frame boundary the window then moves one block of 8 to the right, until the last block has been read. After that it wraps back to the left edge and gives a one-cycle completion pulse. In the fixed mode a central window of 8 columns is tied to the pads and never moves.

The block also reports which of the two readout rates applies. Stepping mode uses the slow 20 MHz rate and fixed mode uses the nominal 80 MHz rate. The mode input is sampled only on a frame-start pulse, so the window and the rate never change in the middle of a frame. The analog multiplexer and the pad buffers are outside this block. They take the 8 column addresses it produces.

Top module: `analog_col_selector`

## Requirements
- R1: After reset the block is in stepping mode: `stripe_o` = 0, `fast_rate_o` = 0, `scan_done_o` = 0, and lane k carries column k.
- R2: Lane k of `col_addr_o` (bits k*10 +: 10) always carries base + k. In stepping mode the base is `stripe_o` × 8.
- R3: In stepping mode, the first frame start after reset keeps stripe 0. Every later frame start in stepping mode advances `stripe_o` by one, one cycle after the pulse is sampled.
- R4: `stripe_o` and the lane addresses change only in the cycle after a frame start has been sampled.
- R5: A frame start while stripe 119 is active returns `stripe_o` to 0. `scan_done_o` is high for exactly that one cycle, and at no other time.
- R6: In fixed mode (`mode_fixed_i` = 1 sampled at a frame start) the lanes carry columns 476 to 483 and `stripe_o` reads 0. This holds for any number of further frame starts.
- R7: A change of `mode_fixed_i` without a frame start has no effect on any output.
- R8: A frame start that moves the block from fixed to stepping mode restarts at stripe 0 for that frame. The next frame start selects stripe 1.
- R9: `fast_rate_o` is 1 (80 MHz) in fixed mode and 0 (20 MHz) in stepping mode, and it updates together with the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_fixed_i | input | 1 | Requested mode: 1 fixed central window, 0 stepping window |
| frame_start_i | input | 1 | One-cycle frame boundary pulse |
| stripe_o | output | 7 | Active stripe index in stepping mode, 0 in fixed mode |
| col_addr_o | output | 80 | Eight 10-bit column addresses, lane k in bits k*10 +: 10 |
| fast_rate_o | output | 1 | Readout rate: 1 = 80 MHz, 0 = 20 MHz |
| scan_done_o | output | 1 | One-cycle pulse when the window wraps past the last stripe |

## Verification
The hardest state to reach is the wrap from stripe 119 back to 0. It needs 120 frame starts in stepping mode with no fixed-mode frame in between, since any such frame restarts the sweep. A random mix of mode requests rarely gets that far. The stimulus therefore runs a directed run of uninterrupted frame starts that crosses the wrap. It also drives the first-frame-after-reset and the fixed-to-stepping restart cases directly. Seeded random traffic with sparse frame starts and mode flips follows, and a bench model checks it.

// File: rtl/colsel_pkg.sv
package colsel_pkg;

   typedef enum logic {
      MODE_STEP  = 1'b0,
      MODE_FIXED = 1'b1
   } colsel_mode_e;

endpackage

// File: rtl/colsel_stripe_ctr.sv
module colsel_stripe_ctr #(
   parameter int NUM_STRIPES = 120,
   parameter int STRIPE_W    = $clog2(NUM_STRIPES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                adv_i,
   input  logic                clr_i,
   output logic [STRIPE_W-1:0] stripe_o,
   output logic                wrap_o
);

   localparam logic [STRIPE_W-1:0] LAST = STRIPE_W'(NUM_STRIPES - 1);

   initial begin
      if (NUM_STRIPES < 2) $error("colsel_stripe_ctr: need at least two stripes");
   end

   logic [STRIPE_W-1:0] stripe_q;
   logic                wrap_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stripe_q <= '0;
         wrap_q   <= 1'b0;
      end else begin
         wrap_q <= 1'b0;
         if (clr_i) begin
            stripe_q <= '0;
         end else if (adv_i) begin
            if (stripe_q == LAST) begin
               stripe_q <= '0;
               wrap_q   <= 1'b1;
            end else begin
               stripe_q <= stripe_q + 1'b1;
            end
         end
      end
   end

   assign stripe_o = stripe_q;
   assign wrap_o   = wrap_q;

   // R3: one step per advance request
   assert_step_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !clr_i && stripe_q != LAST) |=> (stripe_q == $past(stripe_q) + 1'b1));

   // R5: completion pulse only together with a return to stripe 0
   assert_wrap_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_q |-> (stripe_q == '0));

   // R5: the index never leaves its legal range
   assert_stripe_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      stripe_q <= LAST);

   // R4: no request, no movement
   assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_i && !clr_i) |=> $stable(stripe_q));

endmodule

// File: rtl/colsel_lane_addr.sv
module colsel_lane_addr #(
   parameter int NUM_COLS   = 960,
   parameter int WIN        = 8,
   parameter int FIXED_BASE = 476,
   parameter int STRIPE_W   = 7,
   parameter int COL_W      = $clog2(NUM_COLS)
) (
   input  logic                  fixed_i,
   input  logic [STRIPE_W-1:0]   stripe_i,
   output logic [WIN*COL_W-1:0]  addr_o
);

   localparam logic [COL_W-1:0] FIXED_BASE_C = COL_W'(FIXED_BASE);
   localparam logic [COL_W-1:0] WIN_C        = COL_W'(WIN);

   initial begin
      if (FIXED_BASE + WIN > NUM_COLS) $error("colsel_lane_addr: fixed window out of range");
   end

   logic [COL_W-1:0] base;

   always_comb begin
      if (fixed_i) base = FIXED_BASE_C;
      else         base = COL_W'(stripe_i) * WIN_C;
   end

   for (genvar k = 0; k < WIN; k++) begin : g_lane
      assign addr_o[k*COL_W +: COL_W] = base + COL_W'(k);
   end

endmodule

// File: rtl/analog_col_selector.sv
module analog_col_selector
   import colsel_pkg::*;
#(
   parameter int NUM_COLS   = 960,
   parameter int WIN        = 8,
   parameter int FIXED_BASE = 476,
   localparam int NUM_STRIPES = NUM_COLS / WIN,
   localparam int STRIPE_W    = $clog2(NUM_STRIPES),
   localparam int COL_W       = $clog2(NUM_COLS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mode_fixed_i,
   input  logic                 frame_start_i,
   output logic [STRIPE_W-1:0]  stripe_o,
   output logic [WIN*COL_W-1:0] col_addr_o,
   output logic                 fast_rate_o,
   output logic                 scan_done_o
);

   initial begin
      if (WIN < 1)              $error("analog_col_selector: window must be non-empty");
      if (NUM_COLS % WIN != 0)  $error("analog_col_selector: columns must be a multiple of the window");
      if (FIXED_BASE < 0)       $error("analog_col_selector: negative fixed base");
   end

   colsel_mode_e mode_q;
   logic         started_q;
   logic         adv, clr;

   // mode and first-frame tracking, evaluated only at frame starts
   always_comb begin
      adv = 1'b0;
      clr = 1'b0;
      if (frame_start_i) begin
         if (mode_fixed_i)              clr = 1'b1;
         else if (mode_q == MODE_FIXED) clr = 1'b1;
         else if (started_q)            adv = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q    <= MODE_STEP;
         started_q <= 1'b0;
      end else if (frame_start_i) begin
         if (mode_fixed_i) begin
            mode_q    <= MODE_FIXED;
            started_q <= 1'b0;
         end else begin
            mode_q    <= MODE_STEP;
            started_q <= 1'b1;
         end
      end
   end

   colsel_stripe_ctr #(
      .NUM_STRIPES (NUM_STRIPES),
      .STRIPE_W    (STRIPE_W)
   ) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv_i    (adv),
      .clr_i    (clr),
      .stripe_o (stripe_o),
      .wrap_o   (scan_done_o)
   );

   colsel_lane_addr #(
      .NUM_COLS   (NUM_COLS),
      .WIN        (WIN),
      .FIXED_BASE (FIXED_BASE),
      .STRIPE_W   (STRIPE_W),
      .COL_W      (COL_W)
   ) u_addr (
      .fixed_i  (mode_q == MODE_FIXED),
      .stripe_i (stripe_o),
      .addr_o   (col_addr_o)
   );

   assign fast_rate_o = (mode_q == MODE_FIXED);

   // R6: fixed mode pins the stripe index to zero
   assert_fixed_stripe_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fast_rate_o |-> (stripe_o == '0));

   // R6: fixed mode puts the central column on lane 0
   assert_fixed_lane0_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fast_rate_o |-> (col_addr_o[COL_W-1:0] == COL_W'(FIXED_BASE)));

   // R7: without a frame start the rate does not move
   assert_rate_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start_i |=> $stable(fast_rate_o));

   // R8: leaving fixed mode lands on stripe 0
   assert_reenter_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start_i && !mode_fixed_i && fast_rate_o) |=> (stripe_o == '0 && !fast_rate_o));

   // R5: completion pulse never seen in fixed mode
   assert_done_step_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done_o |-> !fast_rate_o);

endmodule

// File: tb/analog_col_selector_test.sv
module analog_col_selector_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_fixed_i = 1'b0;
   logic        frame_start_i = 1'b0;
   logic [6:0]  stripe_o;
   logic [79:0] col_addr_o;
   logic        fast_rate_o;
   logic        scan_done_o;

   int checks = 0;
   int errors = 0;

   // bench model
   int  m_stripe = 0;
   bit  m_fixed = 0;
   bit  m_started = 0;
   bit  m_done = 0;

   always #4 clk = ~clk;

   analog_col_selector uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .mode_fixed_i  (mode_fixed_i),
      .frame_start_i (frame_start_i),
      .stripe_o      (stripe_o),
      .col_addr_o    (col_addr_o),
      .fast_rate_o   (fast_rate_o),
      .scan_done_o   (scan_done_o)
   );

   function automatic int exp_lane(int k);
      return (m_fixed ? 476 : m_stripe * 8) + k;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_all(string req);
      check({req, " stripe"}, int'(stripe_o), m_fixed ? 0 : m_stripe);
      check({req, " R9 rate"}, int'(fast_rate_o), int'(m_fixed));
      check({req, " R5 done"}, int'(scan_done_o), int'(m_done));
      for (int k = 0; k < 8; k++)
         check({req, " R2 lane"}, int'(col_addr_o[k*10 +: 10]), exp_lane(k));
   endtask

   task automatic model(bit fs, bit md);
      m_done = 0;
      if (fs) begin
         if (md) begin
            m_fixed = 1; m_started = 0; m_stripe = 0;
         end else if (m_fixed) begin
            m_fixed = 0; m_started = 1; m_stripe = 0;
         end else if (!m_started) begin
            m_started = 1;
         end else if (m_stripe == 119) begin
            m_stripe = 0; m_done = 1;
         end else begin
            m_stripe++;
         end
      end
   endtask

   task automatic step(bit fs, bit md, string req);
      @(negedge clk);
      frame_start_i = fs;
      mode_fixed_i  = md;
      @(posedge clk);
      model(fs, md);
      #2;
      check_all(req);
   endtask

   initial begin : watchdog
      #1500000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      int seed;
      seed = 32'h5EED_0C01;
      void'($urandom(seed));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check_all("R1 reset");

      // R3: first frame start keeps stripe 0, next advances
      step(1, 0, "R3 first frame");
      check("R3 still zero", int'(stripe_o), 0);
      step(0, 0, "R4 idle");
      step(1, 0, "R3 advance");
      check("R3 at one", int'(stripe_o), 1);

      // R7: mode flips without frame start
      step(0, 1, "R7 flip high");
      step(0, 1, "R7 flip hold");
      step(0, 0, "R7 flip low");
      check("R7 rate", int'(fast_rate_o), 0);

      // R5: sweep across the wrap
      for (int i = 0; i < 118; i++) step(1, 0, "R3 sweep");
      check("R5 at last", int'(stripe_o), 119);
      step(1, 0, "R5 wrap");
      check("R5 pulse", int'(scan_done_o), 1);
      step(0, 0, "R5 pulse end");
      check("R5 single", int'(scan_done_o), 0);

      // R6: fixed mode holds central window over several frames
      step(1, 1, "R6 enter");
      check("R6 lane7", int'(col_addr_o[70 +: 10]), 483);
      for (int i = 0; i < 5; i++) step(1, 1, "R6 hold");

      // R8: back to stepping restarts at 0 then 1
      step(1, 0, "R8 reenter");
      check("R8 zero", int'(stripe_o), 0);
      step(1, 0, "R8 next");
      check("R8 one", int'(stripe_o), 1);

      // random traffic
      for (int i = 0; i < 4000; i++) begin
         bit fs, md;
         fs = ($urandom % 3) == 0;
         md = ($urandom % 20) == 0;
         step(fs, md, "R4 random");
      end

      // long uninterrupted run to hit wrap again from random state
      for (int i = 0; i < 250; i++) step(1, 0, "R5 long");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule